// File: doc/BRIEF.md
# Multi-Source Reset Supervisor

This block gathers every reason a microcontroller may need to restart and turns them into one clean internal reset. There are four sources. The first is an active-low external reset pin. The second is a low-voltage comparator flag. The third is a detector that watches the USB line for a held single-ended zero. The fourth is a watchdog counter that software must service. Any one of them sets a hold latch. A down-counter keeps that latch set for a fixed number of clock cycles after the last request has gone away. A final register retimes the result to the CPU clock before it leaves the block.

The retimed reset is driven out twice: active-high for the core and peripherals, and as an active-low copy for an attached programmable logic module. The asynchronous inputs (pin, comparator and SE0 line) each pass through a two-flop synchronizer first. The comparator path also has a glitch filter, so that short dips do not restart the system. Software can switch the low-voltage source off with an enable bit, and a sticky flag records that a USB bus reset occurred. Neither the enable bit nor the flag is disturbed by the reset this block produces; only power-on clears or presets them.

Top module: `rst_supervisor`

## Requirements
- R1: `psd_rst_n_o` is always the logical inverse of `sys_rst_o`.
- R2: The external pin held low for one or more cycles asserts `sys_rst_o`. `sys_rst_o` falls on the (STRETCH_CYCLES+4)-th rising clock edge after the pin returns high.
- R3: With the low-voltage source enabled, `lv_det_i` held high for fewer than LV_FILT_CYCLES consecutive clock samples causes no reset. Held high for LV_FILT_CYCLES or more, it causes one. After `lv_det_i` drops, `sys_rst_o` falls on the (STRETCH_CYCLES+5)-th rising edge.
- R4: The low-voltage enable (`lv_en_o`) is 1 after power-on. A cycle with `lv_en_wr_i`=1 loads it from `lv_en_wdata_i`. While it is 0 the comparator input has no effect. Its value survives a reset raised by any other source.
- R5: `se0_i` held high for SE0_MIN_CYCLES or more consecutive samples asserts `sys_rst_o` and sets `usb_rst_flag_o`. Shorter runs do neither.
- R6: `usb_rst_flag_o` stays set through the resulting system reset. It is cleared only by a cycle with `usb_flag_clr_i`=1 (a new detection in the same cycle wins).
- R7: With no kick, the WD_WIDTH-bit watchdog counts every cycle while `sys_rst_o` is low and raises a reset on overflow. `sys_rst_o` stays low for exactly 2^WD_WIDTH+2 sampled cycles between watchdog resets.
- R8: `wd_kick_i`=1 clears the watchdog counter, and the counter is held at zero while `sys_rst_o` is high. Kicking at least once every 2^WD_WIDTH cycles prevents any watchdog reset.
- R9: A one-cycle reset request keeps `sys_rst_o` high for exactly STRETCH_CYCLES+1 cycles. In general `sys_rst_o` does not fall until STRETCH_CYCLES cycles have passed with no request.
- R10: While `por_i` is high, `sys_rst_o`=1, `lv_en_o`=1 and `usb_rst_flag_o`=0. `sys_rst_o` falls on the (STRETCH_CYCLES+2)-th rising edge after `por_i` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| por_i | input | 1 | Power-on reset, synchronous, active-high |
| ext_rst_n_i | input | 1 | External reset pin, asynchronous, active-low |
| lv_det_i | input | 1 | Low-voltage comparator output, asynchronous, 1 = supply low |
| lv_en_wr_i | input | 1 | Write strobe for the low-voltage enable bit |
| lv_en_wdata_i | input | 1 | Value written to the low-voltage enable bit |
| se0_i | input | 1 | USB single-ended-zero indication, asynchronous |
| usb_flag_clr_i | input | 1 | Write-one-to-clear strobe for the USB reset flag |
| wd_kick_i | input | 1 | Watchdog service strobe |
| sys_rst_o | output | 1 | Active-high reset for core and peripherals |
| psd_rst_n_o | output | 1 | Active-low reset for the attached logic module |
| lv_en_o | output | 1 | Current low-voltage enable bit |
| usb_rst_flag_o | output | 1 | Sticky USB bus-reset flag |

## Verification
The hardest case to reach from the ports is a watchdog reset with an exactly known timing. The counter is hidden, and with the default width it takes millions of cycles to overflow. The bench therefore uses a 6-bit counter and stops kicking. It waits for the first free-running overflow and then measures both the stretched high interval and the following low interval of `sys_rst_o` against arithmetic values. The boundaries of the comparator filter and the SE0 detector are reached by sweeping the pulse length one cycle at a time through the threshold, with observation windows long enough to cover the whole stretch.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    // One request line per reset source, merged in the top module.
    typedef struct packed {
        logic ext;
        logic lvd;
        logic usb;
        logic wdt;
    } rst_src_t;

    function automatic logic src_any(input rst_src_t s);
        return s.ext | s.lvd | s.usb | s.wdt;
    endfunction

    // Bits needed to hold the value n (at least one).
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/rst_sync2.sv
module rst_sync2 #(
    parameter int unsigned      WIDTH = 1,
    parameter logic [WIDTH-1:0] IDLE  = '0
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] stab_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q <= IDLE;
            stab_q <= IDLE;
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;
endmodule

// File: rtl/rst_lv_filter.sv
module rst_lv_filter
    import rst_sup_pkg::*;
#(
    parameter int unsigned FILT_CYCLES = 40
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lv_i,
    output logic hit_o
);
    localparam int unsigned CW = cnt_bits(FILT_CYCLES);
    localparam logic [CW-1:0] RUN_MAX = CW'(FILT_CYCLES);

    logic [CW-1:0] run_q;

    // Counts consecutive low-supply samples, saturating at the threshold.
    always_ff @(posedge clk_i) begin
        if (rst_i || !lv_i) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign hit_o = (run_q == RUN_MAX);
endmodule

// File: rtl/rst_se0_detect.sv
module rst_se0_detect
    import rst_sup_pkg::*;
#(
    parameter int unsigned MIN_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic se0_i,
    output logic evt_o
);
    localparam int unsigned CW = cnt_bits(MIN_CYCLES);
    localparam logic [CW-1:0] RUN_MAX = CW'(MIN_CYCLES);
    localparam logic [CW-1:0] RUN_PRE = CW'(MIN_CYCLES - 1);

    logic [CW-1:0] run_q;
    logic          evt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !se0_i) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // One pulse per SE0 episode, on the sample that reaches the minimum.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            evt_q <= 1'b0;
        end else begin
            evt_q <= se0_i && (run_q == RUN_PRE);
        end
    end

    assign evt_o = evt_q;
endmodule

// File: rtl/rst_wdog.sv
module rst_wdog #(
    parameter int unsigned WIDTH = 22
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             hold_i,
    input  logic             kick_i,
    output logic             ovf_o,
    output logic [WIDTH-1:0] cnt_o
);
    logic [WIDTH-1:0] cnt_q;
    logic             ovf_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i || kick_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || hold_i || kick_i) begin
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= &cnt_q;
        end
    end

    assign ovf_o = ovf_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rst_sup_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 400000,
    parameter int unsigned LV_FILT_CYCLES = 40,
    parameter int unsigned SE0_MIN_CYCLES = 4,
    parameter int unsigned WD_WIDTH       = 22
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic ext_rst_n_i,
    input  logic lv_det_i,
    input  logic lv_en_wr_i,
    input  logic lv_en_wdata_i,
    input  logic se0_i,
    input  logic usb_flag_clr_i,
    input  logic wd_kick_i,
    output logic sys_rst_o,
    output logic psd_rst_n_o,
    output logic lv_en_o,
    output logic usb_rst_flag_o
);
    localparam int unsigned   SW           = cnt_bits(STRETCH_CYCLES);
    localparam logic [SW-1:0] STRETCH_LOAD = SW'(STRETCH_CYCLES);

    // Asynchronous inputs, bit 0 is the active-low pin (idles high).
    logic [2:0] raw_w;
    logic [2:0] sync_w;
    assign raw_w = {se0_i, lv_det_i, ext_rst_n_i};

    rst_sync2 #(.WIDTH(3), .IDLE(3'b001)) u_sync (
        .clk_i (clk_i),
        .rst_i (por_i),
        .d_i   (raw_w),
        .q_o   (sync_w)
    );

    logic ext_req;
    logic lv_hit;
    logic usb_evt;
    logic wd_ovf;
    logic [WD_WIDTH-1:0] wd_cnt;
    logic sys_rst_q;

    assign ext_req = ~sync_w[0];

    rst_lv_filter #(.FILT_CYCLES(LV_FILT_CYCLES)) u_lvf (
        .clk_i (clk_i),
        .rst_i (por_i),
        .lv_i  (sync_w[1]),
        .hit_o (lv_hit)
    );

    rst_se0_detect #(.MIN_CYCLES(SE0_MIN_CYCLES)) u_se0 (
        .clk_i (clk_i),
        .rst_i (por_i),
        .se0_i (sync_w[2]),
        .evt_o (usb_evt)
    );

    rst_wdog #(.WIDTH(WD_WIDTH)) u_wdt (
        .clk_i  (clk_i),
        .rst_i  (por_i),
        .hold_i (sys_rst_q),
        .kick_i (wd_kick_i),
        .ovf_o  (wd_ovf),
        .cnt_o  (wd_cnt)
    );

    // Software-visible state: only power-on touches these.
    logic lv_en_q;
    logic usb_flag_q;

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            lv_en_q <= 1'b1;
        end else if (lv_en_wr_i) begin
            lv_en_q <= lv_en_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            usb_flag_q <= 1'b0;
        end else if (usb_evt) begin
            usb_flag_q <= 1'b1;
        end else if (usb_flag_clr_i) begin
            usb_flag_q <= 1'b0;
        end
    end

    // Source merge.
    rst_src_t src;
    logic     req_any;

    always_comb begin
        src.ext = ext_req;
        src.lvd = lv_hit & lv_en_q;
        src.usb = usb_evt;
        src.wdt = wd_ovf;
    end

    assign req_any = src_any(src);

    // Hold latch with release stretch.
    logic          hold_q;
    logic [SW-1:0] stretch_q;

    always_ff @(posedge clk_i) begin
        if (por_i) begin
            hold_q    <= 1'b1;
            stretch_q <= STRETCH_LOAD;
        end else if (req_any) begin
            hold_q    <= 1'b1;
            stretch_q <= STRETCH_LOAD;
        end else if (stretch_q != '0) begin
            stretch_q <= stretch_q - 1'b1;
        end else begin
            hold_q    <= 1'b0;
        end
    end

    // Retiming stage to the CPU clock.
    always_ff @(posedge clk_i) begin
        if (por_i) begin
            sys_rst_q <= 1'b1;
        end else begin
            sys_rst_q <= hold_q;
        end
    end

    assign sys_rst_o      = sys_rst_q;
    assign psd_rst_n_o    = ~sys_rst_q;
    assign lv_en_o        = lv_en_q;
    assign usb_rst_flag_o = usb_flag_q;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk
    import rst_sup_pkg::*;
#(
    parameter int unsigned STRETCH_CYCLES = 400000,
    parameter int unsigned WD_WIDTH       = 22
) (
    input logic                clk_i,
    input logic                por_i,
    input logic                lv_en_wr_i,
    input logic                usb_flag_clr_i,
    input logic                sys_rst_o,
    input logic                psd_rst_n_o,
    input logic                lv_en_o,
    input logic                usb_rst_flag_o,
    input logic                ext_req,
    input logic                req_any,
    input logic [WD_WIDTH-1:0] wd_cnt
);
    localparam int unsigned   QW    = cnt_bits(STRETCH_CYCLES + 2);
    localparam logic [QW-1:0] Q_MAX = QW'(STRETCH_CYCLES + 2);
    localparam logic [QW-1:0] Q_MIN = QW'(STRETCH_CYCLES);

    // Cycles since the last merged request, saturating.
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk_i) begin
        if (por_i || req_any) begin
            quiet_q <= '0;
        end else if (quiet_q != Q_MAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    a_r1_psd_inverse: assert property (@(posedge clk_i) disable iff (por_i)
        psd_rst_n_o != sys_rst_o);

    a_r2_ext_asserts: assert property (@(posedge clk_i) disable iff (por_i)
        $past(ext_req, 2) |-> sys_rst_o);

    a_r4_lv_en_holds: assert property (@(posedge clk_i) disable iff (por_i)
        !lv_en_wr_i |=> $stable(lv_en_o));

    a_r6_flag_sticky: assert property (@(posedge clk_i) disable iff (por_i)
        (usb_rst_flag_o && !usb_flag_clr_i) |=> usb_rst_flag_o);

    a_r8_wd_held: assert property (@(posedge clk_i) disable iff (por_i)
        sys_rst_o |=> (wd_cnt == '0));

    a_r9_min_stretch: assert property (@(posedge clk_i) disable iff (por_i)
        $fell(sys_rst_o) |-> (quiet_q >= Q_MIN));

    a_r10_por_state: assert property (@(posedge clk_i)
        por_i |=> (sys_rst_o && lv_en_o && !usb_rst_flag_o));
endmodule

bind rst_supervisor rst_supervisor_chk #(
    .STRETCH_CYCLES (STRETCH_CYCLES),
    .WD_WIDTH       (WD_WIDTH)
) u_chk (
    .clk_i          (clk_i),
    .por_i          (por_i),
    .lv_en_wr_i     (lv_en_wr_i),
    .usb_flag_clr_i (usb_flag_clr_i),
    .sys_rst_o      (sys_rst_o),
    .psd_rst_n_o    (psd_rst_n_o),
    .lv_en_o        (lv_en_o),
    .usb_rst_flag_o (usb_rst_flag_o),
    .ext_req        (ext_req),
    .req_any        (req_any),
    .wd_cnt         (wd_cnt)
);

// File: tb/tb_rst_supervisor.sv
module tb_rst_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int STRETCH    = 12;
    localparam int FILT       = 5;
    localparam int SE0_MIN    = 4;
    localparam int WDW        = 6;
    localparam int WD_SPAN    = 1 << WDW;

    logic clk = 1'b0;
    logic por = 1'b1;
    logic ext_n = 1'b1;
    logic lv = 1'b0;
    logic lv_wr = 1'b0;
    logic lv_wd = 1'b1;
    logic se0 = 1'b0;
    logic clr = 1'b0;
    logic kick = 1'b1;
    logic sys_rst, psd_n, lv_en, uflag;

    int checks = 0;
    int errors = 0;
    int inv_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_supervisor #(
        .STRETCH_CYCLES (STRETCH),
        .LV_FILT_CYCLES (FILT),
        .SE0_MIN_CYCLES (SE0_MIN),
        .WD_WIDTH       (WDW)
    ) dut (
        .clk_i          (clk),
        .por_i          (por),
        .ext_rst_n_i    (ext_n),
        .lv_det_i       (lv),
        .lv_en_wr_i     (lv_wr),
        .lv_en_wdata_i  (lv_wd),
        .se0_i          (se0),
        .usb_flag_clr_i (clr),
        .wd_kick_i      (kick),
        .sys_rst_o      (sys_rst),
        .psd_rst_n_o    (psd_n),
        .lv_en_o        (lv_en),
        .usb_rst_flag_o (uflag)
    );

    // R1 monitor: inverse relation sampled mid-cycle.
    always @(negedge clk) if (psd_n === sys_rst) inv_bad++;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Count rising edges until sys_rst is seen high and then low again.
    task automatic count_to_release(output int n);
        bit seen = 0;
        n = 0;
        while (n < 5000) begin
            @(posedge clk); #1; n++;
            if (sys_rst) seen = 1;
            else if (seen) break;
        end
    endtask

    task automatic count_while(input logic level, output int n);
        n = 0;
        while (n < 5000) begin
            @(posedge clk); #1; n++;
            if (sys_rst != level) break;
        end
    endtask

    // Observe a window and report whether reset appeared, then settle.
    task automatic observe(input int cycles, output int hit);
        int dummy;
        hit = 0;
        for (int i = 0; i < cycles; i++) begin
            @(posedge clk); #1;
            if (sys_rst) hit = 1;
        end
        if (sys_rst) count_while(1'b1, dummy);
    endtask

    initial begin
        int n;
        int hit;
        repeat (4) @(posedge clk);
        #1;
        // R10 reset state
        chk("R10 rst during por", int'(sys_rst), 1);
        chk("R10 lv_en during por", int'(lv_en), 1);
        chk("R10 flag during por", int'(uflag), 0);
        chk("R1 psd during por", int'(psd_n), 0);
        @(negedge clk) por = 1'b0;
        count_while(1'b1, n);
        chk("R10 release after por", n, STRETCH + 2);

        // R2 external pin, several widths
        for (int w = 1; w <= 4; w++) begin
            @(negedge clk) ext_n = 1'b0;
            repeat (w) @(negedge clk);
            ext_n = 1'b1;
            count_to_release(n);
            chk("R2 ext release", n, STRETCH + 4);
        end

        // R3 glitch filter sweep
        for (int p = 1; p <= FILT + 2; p++) begin
            @(negedge clk) lv = 1'b1;
            repeat (p) @(negedge clk);
            lv = 1'b0;
            observe(STRETCH + 20, hit);
            chk($sformatf("R3 lv pulse %0d", p), hit, (p >= FILT) ? 1 : 0);
        end
        @(negedge clk) lv = 1'b1;
        repeat (20) @(negedge clk);
        lv = 1'b0;
        count_to_release(n);
        chk("R3 lv release", n, STRETCH + 5);

        // R4 enable bit
        @(negedge clk) begin lv_wr = 1'b1; lv_wd = 1'b0; end
        @(negedge clk) lv_wr = 1'b0;
        chk("R4 lv_en written 0", int'(lv_en), 0);
        lv = 1'b1;
        repeat (20) @(negedge clk);
        lv = 1'b0;
        observe(40, hit);
        chk("R4 disabled lv ignored", hit, 0);
        @(negedge clk) ext_n = 1'b0;
        @(negedge clk) ext_n = 1'b1;
        count_to_release(n);
        chk("R4 lv_en kept through reset", int'(lv_en), 0);
        @(negedge clk) begin lv_wr = 1'b1; lv_wd = 1'b1; end
        @(negedge clk) lv_wr = 1'b0;
        chk("R4 lv_en written 1", int'(lv_en), 1);

        // R5/R6 SE0 sweep
        for (int p = 1; p <= SE0_MIN + 2; p++) begin
            @(negedge clk) se0 = 1'b1;
            repeat (p) @(negedge clk);
            se0 = 1'b0;
            observe(STRETCH + 20, hit);
            chk($sformatf("R5 se0 run %0d reset", p), hit, (p >= SE0_MIN) ? 1 : 0);
            chk($sformatf("R6 se0 run %0d flag", p), int'(uflag), (p >= SE0_MIN) ? 1 : 0);
            @(negedge clk) clr = 1'b1;
            @(negedge clk) clr = 1'b0;
            chk("R6 flag cleared", int'(uflag), 0);
        end

        // R7/R9 free-running watchdog
        @(negedge clk) kick = 1'b0;
        count_while(1'b0, n);
        for (int k = 0; k < 3; k++) begin
            count_while(1'b1, n);
            chk("R9 one-cycle request stretch", n, STRETCH + 1);
            count_while(1'b0, n);
            chk("R7 watchdog low interval", n, WD_SPAN + 2);
        end
        count_while(1'b1, n);

        // R8 periodic kick prevents overflow
        hit = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk) kick = 1'b1;
            @(negedge clk) kick = 1'b0;
            for (int i = 0; i < WD_SPAN - 4; i++) begin
                @(posedge clk); #1;
                if (sys_rst) hit = 1;
            end
        end
        chk("R8 kicked watchdog quiet", hit, 0);
        @(negedge clk) kick = 1'b1;

        chk("R1 psd inverse over run", inv_bad, 0);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (200000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule